// File: doc/BRIEF.md
# Multi-Policy Stream Merge Arbiter

This block merges several valid/ready input streams that share one payload type into a single output stream. Each input carries a data word and an end-of-burst flag. Only one input is granted at a time. Its valid, data and end flag pass straight through to the output. The output's ready is returned to that input only.

Two elaboration-time parameters choose the behaviour. The ordering policy is one of three:

- **Fixed priority:** the lowest-numbered requester wins.
- **Round robin:** a rotating priority pointer keeps the ports fair.
- **Strict turn:** ports must deliver in index order 0, 1, 2 and so on. The block waits on the port whose turn it is.

The hold policy is also one of three:

- **Free:** the grant may move on any cycle, even while the current beat is stalled.
- **Beat hold:** a grant that has been presented is held until its beat is accepted.
- **Burst hold:** a grant is held until a beat with the end flag set is accepted.

There is no storage on the data path, so a transfer takes zero cycles through the block. The only state is the hold flag, the held port index and one turn register. The turn register is the round-robin pointer or the strict-turn counter.

Top module: `stream_merge_arb`

## Requirements
- R1: With ORDER_MODE=0 (fixed priority), the requesting port with the smallest index is granted whenever no hold is active.
- R2: With ORDER_MODE=1 (round robin), the search starts at a pointer that is 0 after reset. The grant goes to the first requesting port at or above the pointer, wrapping past N-1 to 0. After a closing beat the pointer becomes the granted index plus one, modulo N.
- R3: With ORDER_MODE=2 (strict turn), only the port equal to the turn counter can be granted. Requests from other ports leave the output invalid. The counter starts at 0, advances by one after each closing beat and wraps from N-1 to 0.
- R4: With HOLD_MODE=0 (free), a stalled grant is not kept. A higher-priority request arriving during a stall takes the output in the same cycle, and its data appears on the output.
- R5: With HOLD_MODE=1 (beat hold), a granted port that is stalled keeps the grant in following cycles even if a higher-ranked port requests. The grant is released by the accepted beat.
- R6: With HOLD_MODE=2 (burst hold), the grant stays on one port from its first accepted or stalled beat until a beat with last=1 is accepted. Only that beat is a closing beat: the pointer or turn counter moves only then.
- R7: At most one in_ready bit is high. It belongs to the granted port and is high only when out_valid and out_ready are both high.
- R8: out_valid equals the granted port's in_valid and is low when no grant exists. out_data and out_last equal the granted port's slice of in_data (port i at bits i*DATA_W upward) and its in_last bit.
- R9: Synchronous active-high reset clears any hold, sets the round-robin pointer and the turn counter to 0, and leaves out_valid low while no input requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_PORTS | Per-port request |
| in_ready | output | N_PORTS | Per-port accept, one-hot or zero |
| in_data | input | N_PORTS*DATA_W | Packed payloads, port i at [i*DATA_W +: DATA_W] |
| in_last | input | N_PORTS | Per-port end-of-burst flag |
| out_valid | output | 1 | Merged stream valid |
| out_ready | input | 1 | Merged stream accept |
| out_data | output | DATA_W | Granted payload |
| out_last | output | 1 | Granted end-of-burst flag |

## Verification
Four configurations are tested:

- fixed/free
- round-robin/beat-hold
- strict-turn/burst-hold
- round-robin/burst-hold

Each configuration is driven with request masks that put the pointer or counter in a different place from the lowest requester. That tells apart a rotating search from a fixed scan, and a wrapped counter from a stuck one.

Stall cycles in which a better-ranked port raises its request tell apart free, beat and burst holding. Bursts that end with and without the end flag show whether the turn moves per beat or per burst.

A scoreboard matches every accepted beat's port, data and end flag against the expected grant. A mid-run reset then checks that the pointer returns to port 0.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;
  localparam int ORDER_FIXED = 0;
  localparam int ORDER_RR    = 1;
  localparam int ORDER_TURN  = 2;

  localparam int HOLD_FREE  = 0;
  localparam int HOLD_BEAT  = 1;
  localparam int HOLD_BURST = 2;
endpackage

// File: rtl/stream_arb_pick.sv
// Combinational candidate selection from the request vector and turn register.
module stream_arb_pick #(
  parameter int N_PORTS    = 4,
  parameter int ORDER_MODE = 0,
  parameter int IDX_W      = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] req,
  input  logic [IDX_W-1:0]   base,
  output logic               pick_any,
  output logic [IDX_W-1:0]   pick_idx
);
  import stream_arb_pkg::*;

  generate
    if (ORDER_MODE == ORDER_TURN) begin : g_turn
      // only the port whose turn it is may be picked
      always_comb begin
        pick_any = req[base];
        pick_idx = base;
      end
    end else begin : g_scan
      // circular scan from base; fixed priority keeps base at zero
      always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        for (int k = N_PORTS - 1; k >= 0; k--) begin
          int j;
          j = int'(base) + k;
          if (j >= N_PORTS) j = j - N_PORTS;
          if (req[j]) begin
            pick_any = 1'b1;
            pick_idx = IDX_W'(j);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/stream_arb_state.sv
// Hold flag, held index and the rotating turn register.
module stream_arb_state #(
  parameter int N_PORTS    = 4,
  parameter int ORDER_MODE = 0,
  parameter int HOLD_MODE  = 0,
  parameter int IDX_W      = $clog2(N_PORTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             presented,
  input  logic             close_beat,
  input  logic [IDX_W-1:0] gnt_idx,
  output logic             held,
  output logic [IDX_W-1:0] held_idx,
  output logic [IDX_W-1:0] turn
);
  import stream_arb_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PORTS - 1);
  localparam bit HOLDS = (HOLD_MODE != HOLD_FREE);
  localparam bit TURNS = (ORDER_MODE != ORDER_FIXED);

  logic [IDX_W-1:0] after_gnt;
  assign after_gnt = (gnt_idx == LAST_IDX) ? '0 : gnt_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      held_idx <= '0;
    end else if (close_beat) begin
      held <= 1'b0;
    end else if (presented && HOLDS) begin
      held     <= 1'b1;
      held_idx <= gnt_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      turn <= '0;
    end else if (close_beat && TURNS) begin
      turn <= after_gnt;
    end
  end
endmodule

// File: rtl/stream_arb_mux.sv
// Payload and end-flag selection for the granted port.
module stream_arb_mux #(
  parameter int N_PORTS = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = $clog2(N_PORTS)
) (
  input  logic [IDX_W-1:0]          sel,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  input  logic [N_PORTS-1:0]        in_last,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_last
);
  always_comb begin
    out_data = in_data[int'(sel)*DATA_W +: DATA_W];
    out_last = in_last[sel];
  end
endmodule

// File: rtl/stream_merge_arb.sv
module stream_merge_arb #(
  parameter int N_PORTS    = 4,
  parameter int DATA_W     = 8,
  parameter int ORDER_MODE = 0,
  parameter int HOLD_MODE  = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PORTS-1:0]        in_valid,
  output logic [N_PORTS-1:0]        in_ready,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  input  logic [N_PORTS-1:0]        in_last,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_last
);
  import stream_arb_pkg::*;

  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             held;
  logic [IDX_W-1:0] held_idx;
  logic [IDX_W-1:0] turn;
  logic [IDX_W-1:0] gnt_idx;
  logic             fire;
  logic             close_beat;

  stream_arb_pick #(
    .N_PORTS(N_PORTS), .ORDER_MODE(ORDER_MODE), .IDX_W(IDX_W)
  ) u_pick (
    .req(in_valid), .base(turn), .pick_any(pick_any), .pick_idx(pick_idx)
  );

  // an active hold overrides the fresh candidate
  assign gnt_idx   = held ? held_idx : pick_idx;
  assign out_valid = held ? in_valid[held_idx] : pick_any;

  assign fire = out_valid && out_ready;
  generate
    if (HOLD_MODE == HOLD_BURST) begin : g_close_burst
      assign close_beat = fire && out_last;
    end else begin : g_close_beat
      assign close_beat = fire;
    end
  endgenerate

  stream_arb_state #(
    .N_PORTS(N_PORTS), .ORDER_MODE(ORDER_MODE), .HOLD_MODE(HOLD_MODE), .IDX_W(IDX_W)
  ) u_state (
    .clk(clk), .rst(rst), .presented(out_valid), .close_beat(close_beat),
    .gnt_idx(gnt_idx), .held(held), .held_idx(held_idx), .turn(turn)
  );

  stream_arb_mux #(
    .N_PORTS(N_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_mux (
    .sel(gnt_idx), .in_data(in_data), .in_last(in_last),
    .out_data(out_data), .out_last(out_last)
  );

  generate
    for (genvar i = 0; i < N_PORTS; i++) begin : g_ready
      assign in_ready[i] = fire && (gnt_idx == IDX_W'(i));
    end
  endgenerate
endmodule

// File: rtl/stream_arb_props.sv
module stream_arb_props #(
  parameter int N_PORTS   = 4,
  parameter int HOLD_MODE = 0,
  parameter int IDX_W     = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PORTS-1:0] in_valid,
  input logic [N_PORTS-1:0] in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_last,
  input logic [IDX_W-1:0]   gnt_idx
);
  a_r7_ready_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  a_r7_ready_needs_fire: assert property (@(posedge clk) disable iff (rst)
    (|in_ready) |-> (out_valid && out_ready));

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !(|in_valid) |-> !out_valid);

  generate
    if (HOLD_MODE == 1) begin : g_beat
      a_r5_stall_keeps_grant: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (gnt_idx == $past(gnt_idx)));
    end
    if (HOLD_MODE == 2) begin : g_burst
      a_r6_open_burst_keeps_grant: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && out_last)) |=> (gnt_idx == $past(gnt_idx)));
    end
  endgenerate
endmodule

bind stream_merge_arb stream_arb_props #(
  .N_PORTS(N_PORTS), .HOLD_MODE(HOLD_MODE), .IDX_W(IDX_W)
) u_props (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .gnt_idx(gnt_idx)
);

// File: tb/stream_merge_arb_test.sv
`timescale 1ns/1ps
module stream_merge_arb_test;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int NCFG = 4;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct {
    int          port;
    logic [DW-1:0] data;
    logic        last;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [NP-1:0]    vld  [NCFG];
  logic [NP-1:0]    rdy  [NCFG];
  logic [NP*DW-1:0] dat  [NCFG];
  logic [NP-1:0]    lst  [NCFG];
  logic             ov   [NCFG];
  logic             ordy [NCFG];
  logic [DW-1:0]    od   [NCFG];
  logic             ol   [NCFG];

  // cfg0 fixed/free, cfg1 rr/beat, cfg2 turn/burst, cfg3 rr/burst
  generate
    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
      stream_merge_arb #(
        .N_PORTS(NP), .DATA_W(DW),
        .ORDER_MODE((k == 3) ? 1 : k), .HOLD_MODE((k == 3) ? 2 : k)
      ) uut (
        .clk(clk), .rst(rst), .in_valid(vld[k]), .in_ready(rdy[k]),
        .in_data(dat[k]), .in_last(lst[k]), .out_valid(ov[k]),
        .out_ready(ordy[k]), .out_data(od[k]), .out_last(ol[k])
      );
    end
  endgenerate

  int checks = 0;
  int errors = 0;
  int tick = 0;
  int cur = 0;
  bit done = 0;
  exp_t sb[$];

  function automatic logic [DW-1:0] data_of(int p, int t);
    return DW'(p * 16 + (t % 16));
  endfunction

  // monitor: every accepted beat is popped and compared
  always @(negedge clk) begin
    if (!rst && ov[cur] && ordy[cur]) begin
      int port;
      port = -1;
      for (int i = 0; i < NP; i++) if (rdy[cur][i]) port = i;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected beat cfg%0d: actual port %0d data %h, expected none", cur, port, od[cur]);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (port != e.port || od[cur] !== e.data || ol[cur] !== e.last) begin
          errors++;
          $display("FAIL %s cfg%0d beat: actual port %0d data %h last %b, expected port %0d data %h last %b",
                   e.req, cur, port, od[cur], ol[cur], e.port, e.data, e.last);
        end
      end
    end
  end

  task automatic drive(int k, logic [NP-1:0] vm, logic [NP-1:0] lm, logic rd, int exp_port, string req);
    logic [NP-1:0] exp_rdy;
    @(posedge clk);
    #1;
    tick++;
    cur = k;
    vld[k] = vm;
    lst[k] = lm;
    ordy[k] = rd;
    for (int i = 0; i < NP; i++) dat[k][i*DW +: DW] = data_of(i, tick);
    if (exp_port >= 0 && rd) begin
      exp_t e;
      e.port = exp_port; e.data = data_of(exp_port, tick);
      e.last = lm[exp_port]; e.req = req;
      sb.push_back(e);
    end
    @(negedge clk);
    checks++;
    if (ov[k] !== (exp_port >= 0)) begin
      errors++;
      $display("FAIL %s/R8 cfg%0d out_valid: actual %b expected %b", req, k, ov[k], exp_port >= 0);
    end
    exp_rdy = (exp_port >= 0 && rd) ? NP'(1 << exp_port) : '0;
    checks++;
    if (rdy[k] !== exp_rdy) begin
      errors++;
      $display("FAIL %s/R7 cfg%0d in_ready: actual %b expected %b", req, k, rdy[k], exp_rdy);
    end
    if (exp_port >= 0) begin
      checks++;
      if (od[k] !== data_of(exp_port, tick) || ol[k] !== lm[exp_port]) begin
        errors++;
        $display("FAIL %s/R8 cfg%0d payload: actual %h/%b expected %h/%b",
                 req, k, od[k], ol[k], data_of(exp_port, tick), lm[exp_port]);
      end
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    for (int k = 0; k < NCFG; k++) begin vld[k] = '0; ordy[k] = 1'b0; end
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < NCFG; k++) begin
      vld[k] = '0; lst[k] = '0; dat[k] = '0; ordy[k] = 1'b0;
    end
    do_reset();

    // cfg0: fixed priority, free grant
    drive(0, 4'b0000, 4'b0000, 1, -1, "R9");
    drive(0, 4'b1111, 4'b0000, 1, 0, "R1");
    drive(0, 4'b1110, 4'b0000, 1, 1, "R1");
    drive(0, 4'b1100, 4'b0000, 1, 2, "R1");
    drive(0, 4'b1000, 4'b1000, 1, 3, "R1");
    drive(0, 4'b0100, 4'b0000, 0, 2, "R4");
    drive(0, 4'b0101, 4'b0000, 0, 0, "R4");  // stalled grant moves away
    drive(0, 4'b0101, 4'b0000, 1, 0, "R4");
    drive(0, 4'b0000, 4'b0000, 1, -1, "R8");

    // cfg1: round robin, beat hold
    drive(1, 4'b1111, 4'b0000, 1, 0, "R2");
    drive(1, 4'b1111, 4'b0000, 1, 1, "R2");
    drive(1, 4'b1011, 4'b0000, 1, 3, "R2");
    drive(1, 4'b1111, 4'b0000, 1, 0, "R2");
    drive(1, 4'b0100, 4'b0000, 0, 2, "R5");
    drive(1, 4'b0111, 4'b0000, 0, 2, "R5");  // port 1 would win without hold
    drive(1, 4'b0111, 4'b0000, 1, 2, "R5");
    drive(1, 4'b0011, 4'b0000, 1, 0, "R2");
    drive(1, 4'b0011, 4'b0000, 1, 1, "R2");
    do_reset();
    drive(1, 4'b1111, 4'b0000, 1, 0, "R9");  // pointer back at 0
    drive(1, 4'b0000, 4'b0000, 1, -1, "R8");

    // cfg2: strict turn, burst hold
    drive(2, 4'b0010, 4'b0000, 1, -1, "R3");
    drive(2, 4'b0011, 4'b0001, 1, 0, "R3");
    drive(2, 4'b1110, 4'b0010, 1, 1, "R3");
    drive(2, 4'b0100, 4'b0000, 1, 2, "R6");
    drive(2, 4'b1100, 4'b0000, 0, 2, "R6");
    drive(2, 4'b0100, 4'b0100, 1, 2, "R6");
    drive(2, 4'b1001, 4'b1001, 1, 3, "R3");
    drive(2, 4'b1001, 4'b1001, 1, 0, "R3");  // counter wrapped
    drive(2, 4'b0000, 4'b0000, 1, -1, "R8");

    // cfg3: round robin, burst hold
    drive(3, 4'b0011, 4'b0000, 1, 0, "R6");
    drive(3, 4'b0011, 4'b0000, 1, 0, "R6");
    drive(3, 4'b0011, 4'b0001, 1, 0, "R6");
    drive(3, 4'b0011, 4'b0010, 1, 1, "R2");
    drive(3, 4'b0011, 4'b0001, 1, 0, "R2");
    drive(3, 4'b0000, 4'b0000, 1, -1, "R8");

    @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard drain: actual %0d pending, expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule